// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This block takes one software-level cache maintenance request and breaks it into the commands that a range maintenance walker can run. A request has three parts: an operation (invalidate, clean or flush), a byte start address and an exclusive byte end address. The block outputs a series of commands over a valid/ready handshake. Each command carries either an inclusive, line-aligned address range or a single line address. The block does not run the commands itself, and it does not issue the barrier that follows them.

Each range command is limited in two ways. It never covers more than a fixed number of bytes, and it never crosses a page boundary. Invalidate requests treat their edges with care. A partial line at either end is cleaned and invalidated as a single line, because a plain invalidate would discard bytes that lie outside the request. Clean and flush requests instead widen the request outward to whole lines. A write-through override input removes the clean work: in this mode the cache can never hold dirty lines, so cleaning is unnecessary. A one-cycle done pulse marks the end of each request.

Top module: `maint_splitter`

## Requirements
- R1: `reqReady` is high only while the block is idle. A request is taken on a cycle with `reqValid && reqReady`. `reqReady` stays low from the cycle after acceptance until the block returns to idle.
- R2: Each range command spans at most 1024 bytes, which is 32 lines of 32 bytes (`cmdAddrHi - cmdAddrLo <= 992`).
- R3: No range command crosses a 4096-byte page boundary. A chunk that starts at address `s` ends, exclusively, at the smallest of three values: `s+1024`, the next page boundary above `s`, and the request end.
- R4: For a range command, `cmdAddrLo` is the line-aligned chunk start. `cmdAddrHi` is the exclusive chunk end minus 32. Consecutive chunks are contiguous and appear in ascending order.
- R5: Operation codes are 0 = invalidate, 1 = clean, and 2 or 3 = flush. For an invalidate whose start is not line-aligned, the first command is a single-line clean-and-invalidate (`cmdKind` 0, `cmdAddrLo == cmdAddrHi` = the start rounded down to 32). The start then moves up to the next line boundary.
- R6: After the step in R5, if an invalidate's start is still below its end and the end is not line-aligned, the block issues a single-line clean-and-invalidate of the line that holds the end. The end is then rounded down to a line boundary. The whole lines left over are sent as invalidate-range commands (`cmdKind` 1).
- R7: For clean and flush, the start is rounded down and the end is rounded up to 32-byte boundaries before chunking. Clean chunks are sent as clean-range commands (`cmdKind` 2).
- R8: For flush without override, each chunk produces a clean-range command followed by an invalidate-range command over the same span.
- R9: When `wtOverride` is sampled high at acceptance, a clean request produces no commands, and a flush request produces only its invalidate-range commands.
- R10: A request whose adjusted start is not below its adjusted end produces no range commands and still completes with done.
- R11: `done` is high for exactly one cycle. It rises two cycles after the last handshake of the request: either the final command handshake, or the request acceptance when there are no commands. It is never high together with `cmdValid`.
- R12: While `cmdValid` is high and `cmdReady` is low, `cmdKind`, `cmdAddrLo` and `cmdAddrHi` hold their values and `cmdValid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqOp | input | 2 | Operation: 0 invalidate, 1 clean, 2/3 flush |
| reqStart | input | AW | Byte start address |
| reqEnd | input | AW | Exclusive byte end address |
| wtOverride | input | 1 | Write-through override, sampled at acceptance |
| cmdValid | output | 1 | A command is offered |
| cmdReady | input | 1 | The walker accepts the command |
| cmdKind | output | 2 | 0 line clean+invalidate, 1 range invalidate, 2 range clean |
| cmdAddrLo | output | AW | First line address (inclusive) |
| cmdAddrHi | output | AW | Last line address (inclusive) |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The bench sends three kinds of request to tell the chunk limits apart. Small aligned spans show the basic inclusive-end conversion. Spans longer than 1024 bytes on a single page isolate the size cap. Spans placed just below a page boundary isolate the page cap. Invalidate requests are sent with unaligned starts, unaligned ends, both, and both inside one line; together these separate the two edge cases from each other and from the rounding that clean and flush use. Flush and clean each run with and without the override, which shows which half of each command pair goes away. A throttled ready pattern checks that no command is lost or repeated under backpressure and that done arrives on time.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  localparam logic [1:0] OP_INV   = 2'd0;
  localparam logic [1:0] OP_CLEAN = 2'd1;
  localparam logic [1:0] OP_FLUSH = 2'd2;

  localparam logic [1:0] KIND_LINE_CI    = 2'd0;
  localparam logic [1:0] KIND_RANGE_INV  = 2'd1;
  localparam logic [1:0] KIND_RANGE_CLN  = 2'd2;

  typedef enum logic [1:0] {
    SEL_EDGE_LO = 2'd0,
    SEL_EDGE_HI = 2'd1,
    SEL_RANGE   = 2'd2
  } addr_sel_e;

  typedef struct packed {
    logic      load;
    logic      stepLine;
    logic      trimEnd;
    logic      advance;
    logic      emit;
    addr_sel_e addrSel;
  } mrs_strobe_t;

endpackage

// File: rtl/mrs_datapath.sv
module mrs_datapath
  import mrs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rstN,
  input  mrs_strobe_t   stb,
  input  logic [1:0]    reqOp,
  input  logic [AW-1:0] reqStart,
  input  logic [AW-1:0] reqEnd,
  output logic          curUnaligned,
  output logic          endUnaligned,
  output logic          hasWork,
  output logic [AW-1:0] outLo,
  output logic [AW-1:0] outHi
);

  localparam int XW = AW + 1;
  localparam int LB = $clog2(LINE_BYTES);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam logic [XW-1:0] LINE_MASK = XW'(LINE_BYTES - 1);
  localparam logic [XW-1:0] PAGE_MASK = XW'(PAGE_BYTES - 1);
  localparam logic [XW-1:0] MAX_SPAN  = XW'(MAX_BYTES);
  localparam logic [XW-1:0] LINE_SPAN = XW'(LINE_BYTES);

  // Extra top bit keeps round-up and page-end sums from wrapping.
  logic [XW-1:0] curQ, endQ;
  logic [XW-1:0] startX, endX;
  logic [XW-1:0] capSize, capPage, chunkEnd;

  assign startX = {1'b0, reqStart};
  assign endX   = {1'b0, reqEnd};

  always_comb begin
    capSize  = curQ + MAX_SPAN;
    capPage  = (curQ | PAGE_MASK) + 1'b1;
    chunkEnd = endQ;
    if (capSize < chunkEnd) chunkEnd = capSize;
    if (capPage < chunkEnd) chunkEnd = capPage;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curQ <= '0;
      endQ <= '0;
    end else if (stb.load) begin
      if (reqOp == OP_INV) begin
        curQ <= startX;
        endQ <= endX;
      end else begin
        curQ <= startX & ~LINE_MASK;
        endQ <= (endX + LINE_MASK) & ~LINE_MASK;
      end
    end else begin
      if (stb.stepLine) curQ <= (curQ | LINE_MASK) + 1'b1;
      if (stb.advance)  curQ <= chunkEnd;
      if (stb.trimEnd)  endQ <= endQ & ~LINE_MASK;
    end
  end

  assign curUnaligned = |(curQ & LINE_MASK);
  assign endUnaligned = |(endQ & LINE_MASK);
  assign hasWork      = curQ < endQ;

  always_comb begin
    unique case (stb.addrSel)
      SEL_EDGE_LO: begin
        outLo = AW'(curQ & ~LINE_MASK);
        outHi = AW'(curQ & ~LINE_MASK);
      end
      SEL_EDGE_HI: begin
        outLo = AW'(endQ & ~LINE_MASK);
        outHi = AW'(endQ & ~LINE_MASK);
      end
      default: begin
        outLo = AW'(curQ);
        outHi = AW'(chunkEnd - LINE_SPAN);
      end
    endcase
  end

  // R2
  chunk_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && stb.addrSel == SEL_RANGE) |-> (outHi - outLo) <= AW'(MAX_BYTES - LINE_BYTES));

  // R3
  page_cross_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && stb.addrSel == SEL_RANGE) |-> (outLo[AW-1:PB] == outHi[AW-1:PB]));

  // R4
  lo_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.emit |-> (outLo[LB-1:0] == '0) && (outHi >= outLo));

endmodule

// File: rtl/mrs_control.sv
module mrs_control
  import mrs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqOp,
  input  logic        wtOverride,
  input  logic        curUnaligned,
  input  logic        endUnaligned,
  input  logic        hasWork,
  output logic        cmdValid,
  input  logic        cmdReady,
  output logic [1:0]  cmdKind,
  output logic        done,
  output mrs_strobe_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_EDGE_LO, ST_EDGE_HI, ST_RANGE_A, ST_RANGE_B, ST_FIN
  } state_e;

  state_e stateQ, stateD;
  logic [1:0] opQ;
  logic wtQ;
  logic isInv, isClean, isFlush;

  assign isInv   = (opQ == OP_INV);
  assign isClean = (opQ == OP_CLEAN);
  assign isFlush = opQ[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      opQ    <= OP_INV;
      wtQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stb.load) begin
        opQ <= reqOp;
        wtQ <= wtOverride;
      end
    end
  end

  always_comb begin
    stateD      = stateQ;
    stb         = '0;
    stb.addrSel = SEL_RANGE;
    reqReady    = 1'b0;
    cmdValid    = 1'b0;
    cmdKind     = KIND_RANGE_INV;
    done        = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.load = 1'b1;
          stateD   = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (isInv && curUnaligned)                  stateD = ST_EDGE_LO;
        else if (isInv && hasWork && endUnaligned)  stateD = ST_EDGE_HI;
        else if (hasWork && !(isClean && wtQ))      stateD = ST_RANGE_A;
        else                                        stateD = ST_FIN;
      end
      ST_EDGE_LO: begin
        cmdValid    = 1'b1;
        cmdKind     = KIND_LINE_CI;
        stb.addrSel = SEL_EDGE_LO;
        if (cmdReady) begin
          stb.stepLine = 1'b1;
          stateD       = ST_EVAL;
        end
      end
      ST_EDGE_HI: begin
        cmdValid    = 1'b1;
        cmdKind     = KIND_LINE_CI;
        stb.addrSel = SEL_EDGE_HI;
        if (cmdReady) begin
          stb.trimEnd = 1'b1;
          stateD      = ST_EVAL;
        end
      end
      ST_RANGE_A: begin
        cmdValid = 1'b1;
        cmdKind  = (isInv || wtQ) ? KIND_RANGE_INV : KIND_RANGE_CLN;
        if (cmdReady) begin
          if (isFlush && !wtQ) begin
            stateD = ST_RANGE_B;
          end else begin
            stb.advance = 1'b1;
            stateD      = ST_EVAL;
          end
        end
      end
      ST_RANGE_B: begin
        cmdValid = 1'b1;
        cmdKind  = KIND_RANGE_INV;
        if (cmdReady) begin
          stb.advance = 1'b1;
          stateD      = ST_EVAL;
        end
      end
      ST_FIN: begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
    stb.emit = cmdValid;
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !cmdValid);

  // R1
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9
  wt_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && wtQ) |-> (cmdKind != KIND_RANGE_CLN));

endmodule

// File: rtl/maint_splitter.sv
module maint_splitter
  import mrs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [1:0]    reqOp,
  input  logic [AW-1:0] reqStart,
  input  logic [AW-1:0] reqEnd,
  input  logic          wtOverride,
  output logic          cmdValid,
  input  logic          cmdReady,
  output logic [1:0]    cmdKind,
  output logic [AW-1:0] cmdAddrLo,
  output logic [AW-1:0] cmdAddrHi,
  output logic          done
);

  mrs_strobe_t stb;
  logic curUnaligned, endUnaligned, hasWork;

  mrs_control i_control (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .reqOp        (reqOp),
    .wtOverride   (wtOverride),
    .curUnaligned (curUnaligned),
    .endUnaligned (endUnaligned),
    .hasWork      (hasWork),
    .cmdValid     (cmdValid),
    .cmdReady     (cmdReady),
    .cmdKind      (cmdKind),
    .done         (done),
    .stb          (stb)
  );

  mrs_datapath #(
    .AW         (AW),
    .LINE_BYTES (LINE_BYTES),
    .MAX_BYTES  (MAX_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .reqOp        (reqOp),
    .reqStart     (reqStart),
    .reqEnd       (reqEnd),
    .curUnaligned (curUnaligned),
    .endUnaligned (endUnaligned),
    .hasWork      (hasWork),
    .outLo        (cmdAddrLo),
    .outHi        (cmdAddrHi)
  );

  // R12
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid && $stable(cmdKind) &&
                               $stable(cmdAddrLo) && $stable(cmdAddrHi));

endmodule

// File: tb/test_maint_splitter.sv
`timescale 1ns/1ps
module test_maint_splitter;

  localparam int AW = 32;

  typedef struct {
    int     kind;
    longint lo;
    longint hi;
  } exp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqOp = 2'd0;
  logic [AW-1:0] reqStart = '0;
  logic [AW-1:0] reqEnd = '0;
  logic          wtOverride = 1'b0;
  logic          cmdValid;
  logic          cmdReady = 1'b1;
  logic [1:0]    cmdKind;
  logic [AW-1:0] cmdAddrLo, cmdAddrHi;
  logic          done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lastHs = 0;
  int throttle = 0;
  int rdyCnt = 0;
  bit doneSeen = 0;
  bit finished = 0;
  string curTag = "R4";
  exp_t expQ[$];

  always #2 clk = ~clk;

  maint_splitter #(.AW(AW)) i_maint_splitter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqStart(reqStart), .reqEnd(reqEnd), .wtOverride(wtOverride),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdKind(cmdKind),
    .cmdAddrLo(cmdAddrLo), .cmdAddrHi(cmdAddrHi), .done(done)
  );

  // Backpressure pattern driven away from the sampling edge.
  always @(posedge clk) begin
    #1;
    rdyCnt   = rdyCnt + 1;
    cmdReady = (throttle == 0) ? 1'b1 : ((rdyCnt % 3) == 0);
  end

  task automatic pushExp(int kind, longint lo, longint hi);
    exp_t e;
    e.kind = kind; e.lo = lo; e.hi = hi;
    expQ.push_back(e);
  endtask

  // Behavioural reference: the command list a request must produce.
  task automatic buildExp(int op, longint s, longint e, bit wt);
    longint ce;
    if (op == 0) begin
      if (s % 32 != 0) begin
        pushExp(0, s - s % 32, s - s % 32);
        s = s - s % 32 + 32;
      end
      if (s < e && e % 32 != 0) begin
        pushExp(0, e - e % 32, e - e % 32);
        e = e - e % 32;
      end
      while (s < e) begin
        ce = e;
        if (s + 1024 < ce) ce = s + 1024;
        if ((s / 4096 + 1) * 4096 < ce) ce = (s / 4096 + 1) * 4096;
        pushExp(1, s, ce - 32);
        s = ce;
      end
    end else begin
      s = s - s % 32;
      e = ((e + 31) / 32) * 32;
      if (!(op == 1 && wt)) begin
        while (s < e) begin
          ce = e;
          if (s + 1024 < ce) ce = s + 1024;
          if ((s / 4096 + 1) * 4096 < ce) ce = (s / 4096 + 1) * 4096;
          if (!wt) pushExp(2, s, ce - 32);
          if (op >= 2) pushExp(1, s, ce - 32);
          s = ce;
        end
      end
    end
  endtask

  // Per-clock comparison against the reference list.
  always @(negedge clk) begin
    if (rstN) begin
      cyc = cyc + 1;
      if (reqValid && reqReady) lastHs = cyc;
      if (cmdValid && cmdReady) begin
        checks = checks + 1;
        if (expQ.size() == 0) begin
          errors = errors + 1;
          $display("FAIL %s: unexpected command kind=%0d lo=%h hi=%h, expected none",
                   curTag, cmdKind, cmdAddrLo, cmdAddrHi);
        end else begin
          exp_t x;
          x = expQ.pop_front();
          if (cmdKind != x.kind[1:0] || longint'(cmdAddrLo) != x.lo ||
              longint'(cmdAddrHi) != x.hi) begin
            errors = errors + 1;
            $display("FAIL %s: got kind=%0d lo=%h hi=%h, expected kind=%0d lo=%h hi=%h",
                     curTag, cmdKind, cmdAddrLo, cmdAddrHi, x.kind, x.lo, x.hi);
          end
        end
        lastHs = cyc;
      end
      if (done) begin
        checks = checks + 1;
        if (cyc != lastHs + 2 || expQ.size() != 0) begin
          errors = errors + 1;
          $display("FAIL R11 (%s): done at cycle %0d with %0d pending, expected cycle %0d with 0 pending",
                   curTag, cyc, expQ.size(), lastHs + 2);
        end
        doneSeen = 1;
      end
    end
  end

  task automatic runReq(int op, longint s, longint e, bit wt, int thr, string tag);
    int n;
    curTag   = tag;
    throttle = thr;
    buildExp(op, s, e, wt);
    doneSeen = 0;
    @(posedge clk); #1;
    reqValid   = 1'b1;
    reqOp      = op[1:0];
    reqStart   = AW'(s);
    reqEnd     = AW'(e);
    wtOverride = wt;
    @(posedge clk); #1;
    reqValid   = 1'b0;
    wtOverride = ~wt;  // must not matter after acceptance (R9)
    @(negedge clk);
    checks = checks + 1;
    if (reqReady !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R1: reqReady=%b while busy, expected 0", reqReady);
    end
    n = 0;
    while (!doneSeen && n < 3000) begin
      @(negedge clk);
      n = n + 1;
    end
    if (!doneSeen) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL %s: done=0 after %0d cycles, expected 1", tag, n);
    end
    @(negedge clk);
    checks = checks + 1;
    if (reqReady !== 1'b1 || expQ.size() != 0) begin
      errors = errors + 1;
      $display("FAIL R1 (%s): reqReady=%b pending=%0d, expected 1 and 0",
               tag, reqReady, expQ.size());
    end
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checks = checks + 1;
    if (reqReady !== 1'b1 || cmdValid !== 1'b0 || done !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R1: reset state ready=%b valid=%b done=%b, expected 1 0 0",
               reqReady, cmdValid, done);
    end

    runReq(1, 64'h1000, 64'h1100, 0, 0, "R4");   // single small clean chunk
    runReq(1, 64'h2000, 64'h2900, 0, 0, "R2");   // 1024-byte cap
    runReq(1, 64'h0F80, 64'h1040, 0, 0, "R3");   // page cap
    runReq(1, 64'h3005, 64'h3041, 0, 0, "R7");   // clean rounding
    runReq(2, 64'h7FE8, 64'h8420, 0, 0, "R7");   // flush rounding + page
    runReq(0, 64'h4010, 64'h4090, 0, 0, "R5");   // both invalidate edges
    runReq(0, 64'h4400, 64'h4444, 0, 0, "R6");   // end edge only
    runReq(0, 64'h5004, 64'h5010, 0, 0, "R6");   // both inside one line
    runReq(0, 64'h6000, 64'h7000, 0, 0, "R2");   // 4 invalidate chunks
    runReq(2, 64'h9000, 64'h9800, 0, 0, "R8");   // flush pairs
    runReq(3, 64'hA3E0, 64'hA420, 0, 0, "R8");   // op 3 acts as flush
    runReq(1, 64'hB000, 64'hB800, 1, 0, "R9");   // override clean: nothing
    runReq(2, 64'hBFC0, 64'hC440, 1, 0, "R9");   // override flush: inv only
    runReq(1, 64'hD000, 64'hD000, 0, 0, "R10");  // empty clean
    runReq(0, 64'hD100, 64'hD0E0, 0, 0, "R10");  // end below start
    runReq(2, 64'hE010, 64'hE9F0, 0, 1, "R12");  // flush under backpressure
    runReq(0, 64'hF3F8, 64'hF828, 0, 1, "R12");  // invalidate under backpressure

    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule